// File: doc/BRIEF.md
# Dual-Chunk Hamming ECC Generator

This block computes a single-error-correcting Hamming check code for one 512-byte flash page. It snoops the controller's 16-bit data transfers and treats the page as two 256-byte chunks, each with its own code. Each transfer word carries two bytes, and the block consumes both bytes in the same cycle. Each code has sixteen line-parity bits and six column-parity bits. Correction is done by the host, which compares the stored and recomputed codes.

Software drives the block with 8-bit mode commands. A clear command empties the accumulators and rewinds the byte position. A calculate command makes later transfers count toward the code. A result command turns data-register reads into readout of three 16-bit check words. The first read after a clear is a dummy read and does not disturb the code, because the block only accumulates in calculate mode.

Top module: `ecc_dual_chunk_gen`

## Requirements
- R1: After rst_n is released the block is idle, both accumulators and the byte position are zero, and rd_word reads 0.
- R2: Mode code 0xF4 clears both accumulators and the byte position and leaves the block idle. Code 0xB4 enters calculate mode. Code 0xD4 enters result mode. Any other code makes the block idle. With no mode write, the mode is held.
- R3: A transfer accepted in calculate mode carries two bytes. Bits 7:0 are the byte at the current position p, and bits 15:8 are the byte at position p+1. The position then advances by 2.
- R4: A transfer made outside calculate mode changes neither the accumulators nor the position. This covers the dummy read after a clear and transfers in result mode.
- R5: Positions 0 to 255 feed chunk 0 and positions 256 to 511 feed chunk 1. The byte address inside a chunk is the position modulo 256. Bytes at position 512 and beyond are ignored.
- R6: Line parity bits 2k and 2k+1 (k = 0..7) of a chunk are the XOR of the byte parities of that chunk's bytes whose address bit k is 0 and 1 respectively.
- R7: A chunk's column byte holds CP5..CP0 in bits 7..2, and bits 1..0 are 1. CP(2m+s) is the XOR, over all the chunk's bytes, of the data bits whose bit-index bit m equals s (m = 0..2, s = 0..1).
- R8: The three readout words are packed as follows. Word 0 is {chunk-0 LP15..8, chunk-0 LP7..0}. Word 1 is {chunk-1 LP7..0, chunk-0 column byte}. Word 2 is {chunk-1 column byte, chunk-1 LP15..8}. Each is listed high byte first.
- R9: A result command selects word 0. Each rd_en pulse in result mode moves to the next word after that edge, in the order 0, 1, 2, 0. rd_word shows the selected word during result mode and reads 0 in every other mode.
- R10: Leaving calculate mode and returning to it without a clear resumes accumulation at the saved position, with the code built so far kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode command strobe |
| mode_code | input | 8 | Mode command value |
| xfer_vld | input | 1 | A data transfer happens this cycle |
| xfer_word | input | XFER_W | Data transfer word, two bytes |
| rd_en | input | 1 | Data-register read strobe |
| rd_word | output | 16 | Selected check word in result mode, else 0 |

## Verification
The bench builds the block with its default parameters: 256-byte chunks and a 16-bit transfer word. With these values one full page takes only 256 transfer cycles. That makes the chunk boundary at byte 256, the end of the page at byte 512 and the overrun beyond it cheap to cover in every run. A reference model computes the code from the bytes fed in calculate mode. A hand-worked single-byte case also pins down the byte order and the bit packing without relying on that model.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_RESULT = 2'd2
  } ecc_state_t;

  localparam logic [7:0] CMD_CLEAR  = 8'hF4;
  localparam logic [7:0] CMD_CALC   = 8'hB4;
  localparam logic [7:0] CMD_RESULT = 8'hD4;

  localparam int NUM_CHUNKS = 2;
  localparam int NUM_WORDS  = 3;
  localparam int RES_W      = 16;

  // Folds the XOR of all bytes of a chunk into its column byte.
  function automatic logic [7:0] col_code(input logic [7:0] x);
    logic [5:0] cp;
    cp[0] = x[0] ^ x[2] ^ x[4] ^ x[6];
    cp[1] = x[1] ^ x[3] ^ x[5] ^ x[7];
    cp[2] = x[0] ^ x[1] ^ x[4] ^ x[5];
    cp[3] = x[2] ^ x[3] ^ x[6] ^ x[7];
    cp[4] = x[0] ^ x[1] ^ x[2] ^ x[3];
    cp[5] = x[4] ^ x[5] ^ x[6] ^ x[7];
    return {cp, 2'b11};
  endfunction

endpackage

// File: rtl/ecc_byte_lane.sv
module ecc_byte_lane #(
  parameter int CHUNK_AW = 8,
  parameter int CNT_W    = CHUNK_AW + 2
) (
  input  logic                    en,
  input  logic [CNT_W-1:0]        pos,
  input  logic [7:0]              data,
  output logic                    hit,
  output logic                    chunk,
  output logic [2*CHUNK_AW-1:0]   lp_tog,
  output logic [7:0]              col
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 ** (CHUNK_AW + 1));

  logic par;

  always_comb begin
    hit   = en && (pos < LIMIT);
    chunk = pos[CHUNK_AW];
    par   = ^data;
    col   = hit ? data : 8'h00;
    for (int k = 0; k < CHUNK_AW; k++) begin
      lp_tog[2*k+1] = hit & par & pos[k];
      lp_tog[2*k]   = hit & par & ~pos[k];
    end
  end

endmodule

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc #(
  parameter int CHUNK_AW = 8,
  parameter int LANES    = 2,
  parameter int CHUNK_ID = 0,
  localparam int LP_W    = 2 * CHUNK_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [LANES-1:0]        lane_hit,
  input  logic [LANES-1:0]        lane_chunk,
  input  logic [LANES*LP_W-1:0]   lane_lp,
  input  logic [LANES*8-1:0]      lane_col,
  output logic [LP_W-1:0]         lp_q,
  output logic [7:0]              col_q
);

  logic [LP_W-1:0] lp_d;
  logic [7:0]      col_d;
  logic            acc_en;

  always_comb begin
    lp_d   = lp_q;
    col_d  = col_q;
    acc_en = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_hit[l] && (lane_chunk[l] == 1'(CHUNK_ID))) begin
        acc_en = 1'b1;
        lp_d   = lp_d ^ lane_lp[l*LP_W +: LP_W];
        col_d  = col_d ^ lane_col[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (clr) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (acc_en) begin
      lp_q  <= lp_d;
      col_q <= col_d;
    end
  end

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import ecc_gen_pkg::*;
#(
  parameter int LP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             active,
  input  logic [LP_W-1:0]  lp0,
  input  logic [LP_W-1:0]  lp1,
  input  logic [7:0]       colx0,
  input  logic [7:0]       colx1,
  output logic [1:0]       ptr,
  output logic [RES_W-1:0] rd_word
);

  logic [RES_W-1:0] lpw0, lpw1;
  logic [7:0]       cc0, cc1;
  logic [RES_W-1:0] words [NUM_WORDS];
  logic [1:0]       ptr_d;
  logic             ptr_en;

  always_comb begin
    lpw0     = RES_W'(lp0);
    lpw1     = RES_W'(lp1);
    cc0      = col_code(colx0);
    cc1      = col_code(colx1);
    words[0] = lpw0;
    words[1] = {lpw1[7:0], cc0};
    words[2] = {cc1, lpw1[15:8]};
  end

  always_comb begin
    ptr_en = start | step;
    if (start)
      ptr_d = 2'd0;
    else if (ptr == 2'(NUM_WORDS - 1))
      ptr_d = 2'd0;
    else
      ptr_d = ptr + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= 2'd0;
    else if (ptr_en)
      ptr <= ptr_d;
  end

  always_comb begin
    rd_word = '0;
    if (active) begin
      case (ptr)
        2'd0:    rd_word = words[0];
        2'd1:    rd_word = words[1];
        2'd2:    rd_word = words[2];
        default: rd_word = '0;
      endcase
    end
  end

endmodule

// File: rtl/ecc_dual_chunk_gen.sv
module ecc_dual_chunk_gen
  import ecc_gen_pkg::*;
#(
  parameter int CHUNK_AW = 8,
  parameter int XFER_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [7:0]        mode_code,
  input  logic              xfer_vld,
  input  logic [XFER_W-1:0] xfer_word,
  input  logic              rd_en,
  output logic [15:0]       rd_word
);

  localparam int BUS_BYTES = XFER_W / 8;
  localparam int LP_W      = 2 * CHUNK_AW;
  localparam int CNT_W     = CHUNK_AW + 2;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 ** (CHUNK_AW + 1));

  ecc_state_t       st_q, st_d;
  logic [CNT_W-1:0] pos_q, pos_d, pos_step;
  logic [CNT_W:0]   pos_sum;
  logic             clr, take, pos_en;

  logic [BUS_BYTES-1:0]      lane_hit, lane_chunk;
  logic [BUS_BYTES*LP_W-1:0] lane_lp;
  logic [BUS_BYTES*8-1:0]    lane_col;

  logic [NUM_CHUNKS-1:0][LP_W-1:0] lp_acc;
  logic [NUM_CHUNKS-1:0][7:0]      col_acc;
  logic [1:0]                      rd_ptr;
  logic                            res_start, res_step;

  // Mode decode: next state and clear strobe.
  always_comb begin
    st_d = st_q;
    clr  = 1'b0;
    if (mode_we) begin
      case (mode_code)
        CMD_CLEAR: begin
          st_d = ST_IDLE;
          clr  = 1'b1;
        end
        CMD_CALC:   st_d = ST_CALC;
        CMD_RESULT: st_d = ST_RESULT;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  // Byte position: advances per accepted word, saturates at the page end.
  always_comb begin
    take     = xfer_vld && (st_q == ST_CALC) && !clr;
    pos_sum  = {1'b0, pos_q} + (CNT_W+1)'(BUS_BYTES);
    pos_step = (pos_sum >= {1'b0, LIMIT}) ? LIMIT : pos_sum[CNT_W-1:0];
    pos_en   = clr | take;
    pos_d    = clr ? '0 : pos_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_IDLE;
    else
      st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (pos_en)
      pos_q <= pos_d;
  end

  // One lane per byte of the transfer word, low byte first.
  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    logic [CNT_W-1:0] lane_pos;
    assign lane_pos = pos_q + CNT_W'(g);
    ecc_byte_lane #(
      .CHUNK_AW (CHUNK_AW),
      .CNT_W    (CNT_W)
    ) u_lane (
      .en     (take),
      .pos    (lane_pos),
      .data   (xfer_word[g*8 +: 8]),
      .hit    (lane_hit[g]),
      .chunk  (lane_chunk[g]),
      .lp_tog (lane_lp[g*LP_W +: LP_W]),
      .col    (lane_col[g*8 +: 8])
    );
  end

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    ecc_chunk_acc #(
      .CHUNK_AW (CHUNK_AW),
      .LANES    (BUS_BYTES),
      .CHUNK_ID (c)
    ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .lane_hit   (lane_hit),
      .lane_chunk (lane_chunk),
      .lane_lp    (lane_lp),
      .lane_col   (lane_col),
      .lp_q       (lp_acc[c]),
      .col_q      (col_acc[c])
    );
  end

  assign res_start = mode_we && (mode_code == CMD_RESULT);
  assign res_step  = rd_en && !mode_we && (st_q == ST_RESULT);

  ecc_readout #(
    .LP_W (LP_W)
  ) u_readout (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (res_start),
    .step    (res_step),
    .active  (st_q == ST_RESULT),
    .lp0     (lp_acc[0]),
    .lp1     (lp_acc[1]),
    .colx0   (col_acc[0]),
    .colx1   (col_acc[1]),
    .ptr     (rd_ptr),
    .rd_word (rd_word)
  );

endmodule

// File: rtl/ecc_gen_chk.sv
module ecc_gen_chk
  import ecc_gen_pkg::*;
#(
  parameter int CHUNK_AW = 8,
  localparam int LP_W    = 2 * CHUNK_AW,
  localparam int CNT_W   = CHUNK_AW + 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            mode_we,
  input logic [7:0]                      mode_code,
  input logic                            rd_en,
  input logic [15:0]                     rd_word,
  input ecc_state_t                      st_q,
  input logic [CNT_W-1:0]                pos_q,
  input logic [1:0]                      rd_ptr,
  input logic [NUM_CHUNKS-1:0][LP_W-1:0] lp_acc,
  input logic [NUM_CHUNKS-1:0][7:0]      col_acc
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 ** (CHUNK_AW + 1));

  // R2
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_code == CMD_CLEAR) |=> (pos_q == '0 && lp_acc == '0 && col_acc == '0));

  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CALC && !mode_we) |=> ($stable(lp_acc) && $stable(col_acc) && $stable(pos_q)));

  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LIMIT);

  // R7
  col_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESULT && rd_ptr == 2'd1) |-> rd_word[1:0] == 2'b11);

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESULT && rd_en && !mode_we && rd_ptr == 2'd2) |=> rd_ptr == 2'd0);

  // R9
  quiet_outside_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RESULT) |-> rd_word == 16'h0000);

endmodule

bind ecc_dual_chunk_gen ecc_gen_chk #(.CHUNK_AW(CHUNK_AW)) u_ecc_gen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_we   (mode_we),
  .mode_code (mode_code),
  .rd_en     (rd_en),
  .rd_word   (rd_word),
  .st_q      (st_q),
  .pos_q     (pos_q),
  .rd_ptr    (rd_ptr),
  .lp_acc    (lp_acc),
  .col_acc   (col_acc)
);

// File: tb/test_ecc_dual_chunk_gen.sv
`timescale 1ns/1ps
module test_ecc_dual_chunk_gen;

  localparam int CHUNK_AW = 8;
  localparam int XFER_W   = 16;
  localparam int CHUNK    = 2 ** CHUNK_AW;
  localparam int PAGE     = 2 * CHUNK;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_we;
  logic [7:0]        mode_code;
  logic              xfer_vld;
  logic [XFER_W-1:0] xfer_word;
  logic              rd_en;
  logic [15:0]       rd_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  mbytes [$];
  bit          m_calc;
  logic [15:0] exp_w   [$];
  string       exp_tag [$];

  always #2.5 clk = ~clk;

  ecc_dual_chunk_gen #(.CHUNK_AW(CHUNK_AW), .XFER_W(XFER_W)) i_ecc_dual_chunk_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_code (mode_code),
    .xfer_vld  (xfer_vld),
    .xfer_word (xfer_word),
    .rd_en     (rd_en),
    .rd_word   (rd_word)
  );

  // Reference code from the bytes fed in calculate mode (R5, R6, R7, R8).
  function automatic void model_words(output logic [15:0] w0, output logic [15:0] w1,
                                      output logic [15:0] w2);
    logic [15:0] lp [2];
    logic [7:0]  cx [2];
    logic [7:0]  cc [2];
    for (int c = 0; c < 2; c++) begin
      lp[c] = '0;
      cx[c] = '0;
    end
    for (int i = 0; i < mbytes.size() && i < PAGE; i++) begin
      int   ch;
      int   a;
      logic p;
      ch = i / CHUNK;
      a  = i % CHUNK;
      p  = ^mbytes[i];
      cx[ch] = cx[ch] ^ mbytes[i];
      if (p) begin
        for (int k = 0; k < CHUNK_AW; k++) begin
          if (((a >> k) & 1) == 1) lp[ch][2*k+1] = ~lp[ch][2*k+1];
          else                     lp[ch][2*k]   = ~lp[ch][2*k];
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      logic [5:0] cp;
      cp = '0;
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 2; s++)
          for (int b = 0; b < 8; b++)
            if (((b >> m) & 1) == s) cp[2*m+s] = cp[2*m+s] ^ cx[c][b];
      cc[c] = {cp, 2'b11};
    end
    w0 = lp[0];
    w1 = {lp[1][7:0], cc[0]};
    w2 = {cc[1], lp[1][15:8]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_mode(input logic [7:0] c);
    @(posedge clk); #1;
    mode_we = 1'b1; mode_code = c;
    @(posedge clk); #1;
    mode_we = 1'b0;
    if (c == 8'hF4) begin
      mbytes.delete();
      m_calc = 1'b0;
    end else begin
      m_calc = (c == 8'hB4);
    end
  endtask

  task automatic send_words(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = 16'((i * 16'h9E37 + seed * 16'h3B1 + (i >> 3)) ^ (i << 11));
      @(posedge clk); #1;
      xfer_vld = 1'b1; xfer_word = w;
      if (m_calc) begin
        mbytes.push_back(w[7:0]);
        mbytes.push_back(w[15:8]);
      end
    end
    @(posedge clk); #1;
    xfer_vld = 1'b0;
  endtask

  task automatic send_one(input logic [15:0] w);
    @(posedge clk); #1;
    xfer_vld = 1'b1; xfer_word = w;
    if (m_calc) begin
      mbytes.push_back(w[7:0]);
      mbytes.push_back(w[15:8]);
    end
    @(posedge clk); #1;
    xfer_vld = 1'b0;
  endtask

  task automatic push_exp(input logic [15:0] w, input string tag);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic expect_ecc(input string tag);
    logic [15:0] w0, w1, w2;
    model_words(w0, w1, w2);
    push_exp(w0, {tag, " word0"});
    push_exp(w1, {tag, " word1"});
    push_exp(w2, {tag, " word2"});
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rd_en = 1'b1;
    end
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // Scoreboard monitor: compares each read against the next expected word.
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_w.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9: read %h with no expected word queued", rd_word);
      end else begin
        check(exp_tag.pop_front(), rd_word, exp_w.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_we = 1'b0; mode_code = 8'h00;
    xfer_vld = 1'b0; xfer_word = '0; rd_en = 1'b0; m_calc = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: idle after reset, output quiet
    @(negedge clk);
    check("R1 reset rd_word", rd_word, 16'h0000);

    // R2 R9: clear then result with no data, then a wrapping fourth read
    send_mode(8'hF4);
    send_mode(8'hD4);
    push_exp(16'h0000, "R2 empty word0");
    push_exp(16'h0003, "R7 empty word1");
    push_exp(16'h0300, "R8 empty word2");
    push_exp(16'h0000, "R9 wrap to word0");
    read_n(4);

    // R3 R6 R7 R8: single known byte 0x01 at position 0
    send_mode(8'hF4);
    send_mode(8'hB4);
    send_one(16'h0001);
    send_mode(8'hD4);
    push_exp(16'h5555, "R3 R6 hand word0");
    push_exp(16'h0057, "R7 hand word1");
    push_exp(16'h0300, "R8 hand word2");
    read_n(3);

    // R4 R5: dummy read after clear, then a full page
    send_mode(8'hF4);
    send_one(16'hA5C3);
    send_mode(8'hB4);
    send_words(PAGE / 2, 1);
    send_mode(8'hD4);
    expect_ecc("R5 full page");
    read_n(3);

    // R6: short partial chunk
    send_mode(8'hF4);
    send_mode(8'hB4);
    send_words(10, 7);
    send_mode(8'hD4);
    expect_ecc("R6 partial");
    read_n(3);

    // R5: overrun beyond the page end is ignored
    send_mode(8'hF4);
    send_mode(8'hB4);
    send_words(300, 3);
    send_mode(8'hD4);
    expect_ecc("R5 overrun");
    read_n(3);

    // R10 R2 R4: pause via another mode code, transfers ignored, then resume
    send_mode(8'hF4);
    send_mode(8'hB4);
    send_words(50, 11);
    send_mode(8'h94);
    @(negedge clk);
    check("R2 other code idle rd_word", rd_word, 16'h0000);
    send_words(5, 99);
    send_mode(8'hB4);
    send_words(90, 12);
    send_mode(8'hD4);
    expect_ecc("R10 resume");
    read_n(3);

    // R9: a new result command restarts at word 0
    push_exp(exp_w.size() == 0 ? 16'h0 : 16'h0, "R9 unused");
    void'(exp_w.pop_back());
    void'(exp_tag.pop_back());
    begin
      logic [15:0] w0, w1, w2;
      model_words(w0, w1, w2);
      push_exp(w0, "R9 partial read word0");
      read_n(1);
      send_mode(8'hD4);
      expect_ecc("R9 restart");
      read_n(3);
    end

    // R4: transfers in result mode change nothing
    send_words(20, 5);
    expect_ecc("R4 result-mode xfer");
    read_n(3);

    // R9: quiet again once result mode is left
    send_mode(8'h00);
    @(negedge clk);
    check("R9 left result rd_word", rd_word, 16'h0000);

    if (exp_w.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R9: %0d reads missing, expected 0", exp_w.size());
    end
    finish_run();
  end

endmodule